// File: doc/BRIEF.md
# Configuration Register Target on a Two-Wire Serial Bus

This block lets an external bus controller read and write a small configuration store over a two-wire, I2C-compatible serial bus. It answers to one 7-bit device address, of which the upper six bits are fixed and the lowest bit comes from a strap pin, so two of these targets can share one bus. A write transfer carries the register pointer as its first byte after the address, and every later byte lands at the pointer, which then advances by one. A read first sets the pointer through a short write phase, then uses a repeated START and the address with the read bit set; bytes then come back from the pointer onward.

The register space is 24 bytes wide. The lower 20 hold real storage that is presented in parallel on a flat output vector for the surrounding logic, and each accepted write also appears for one cycle on a strobe port with its index and value. The top four locations are placeholders: writes to them are acknowledged and dropped, reads from them give zero. Both bus lines are brought into the system clock through two synchronising flops before any edge decision, and the data line is driven only low (open drain); the bus is released otherwise.

Top module: `cfgi2c_target`

## Requirements
- R1: The block acknowledges only the address byte whose upper seven bits equal 1101110 when the strap is 0, or 1101111 when the strap is 1. On any other address it leaves the acknowledge slot released and ignores all bus traffic until the next START.
- R2: In a write transfer the first byte after the address loads the pointer and is acknowledged; every later byte is acknowledged and stored at the pointer, after which the pointer advances by one.
- R3: After a repeated START and the address with bit 0 equal to 1, the block returns the register at the pointer and then the following registers, advancing the pointer by one per byte sent.
- R4: Bytes move most significant bit first with one acknowledge slot after each byte. The block pulls the data line low only to acknowledge a received byte or to send a 0 data bit, changes its drive only while the clock line is low, and never drives during the controller's acknowledge slot.
- R5: A STOP after any complete byte ends the transfer; bytes clocked after it without a new START are neither acknowledged nor stored.
- R6: The pointer wraps from 23 to 0; a pointer byte of 24 or more loads the pointer with 0.
- R7: During a read, an acknowledge of 0 from the controller requests the next byte; an acknowledge of 1 ends data output and the data line stays released until the next START or STOP.
- R8: Writes to indices 20 to 23 are acknowledged but change no storage and raise no strobe; reads of those indices return 0.
- R9: Each stored byte raises the write strobe for exactly one clock with the index and value; byte i of the store appears on bits 8i+7 down to 8i of the flat output.
- R10: After reset the store holds zeros, the data line is released, the pointer is 0 and the strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous reset, active high |
| addr_strap | input | 1 | Lowest bit of the device address |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_low | output | 1 | When 1 the pad pulls the data line low |
| cfg_flat | output | 160 | Stored registers 0 to 19, byte i at bits 8i+7:8i |
| rf_wr_en | output | 1 | One-cycle pulse per stored byte |
| rf_wr_addr | output | 5 | Index of the byte being stored |
| rf_wr_data | output | 8 | Value of the byte being stored |

## Verification
A wrong pointer shows at the ports on the very next data byte: a write lands on the wrong slice of the flat output and a read returns a value the reference model did not predict, so the fault appears within one byte time. A broken bit counter or acknowledge timing shifts every later byte and turns acknowledges into NACKs in the same transfer. A fault in the placeholder range or the wrap shows when a block crosses index 19 or 23, which the bench forces on purpose, and a stale state after STOP or NACK shows as a pull on the data line where the bench expects it released.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

    // register space geometry
    localparam int REG_COUNT  = 24;
    localparam int LIVE_COUNT = 20;
    localparam int IDX_W      = $clog2(REG_COUNT);
    localparam int BYTE_W     = 8;
    localparam int BIT_CNT_W  = $clog2(BYTE_W);

    // fixed upper part of the 7-bit device address
    localparam logic [5:0] DEV_ADDR_HI = 6'b110111;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_RX_ACK,
        PH_TX,
        PH_TX_ACK
    } phase_e;

    typedef enum logic [1:0] {
        RK_DEV,
        RK_PTR,
        RK_DATA
    } rxkind_e;

    // bus events after synchronisation
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    // write request to the store
    typedef struct packed {
        logic              en;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

endpackage

// File: rtl/cfgi2c_linesync.sv
module cfgi2c_linesync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q,
    output logic q_prev
);
    logic [STAGES-1:0] stage;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= {STAGES{RESET_VAL}};
            prev  <= RESET_VAL;
        end else begin
            stage <= {stage[STAGES-2:0], d};
            prev  <= stage[STAGES-1];
        end
    end

    assign q      = stage[STAGES-1];
    assign q_prev = prev;

endmodule

// File: rtl/cfgi2c_regfile.sv
module cfgi2c_regfile
    import cfgi2c_pkg::*;
#(
    parameter int LIVE = LIVE_COUNT
) (
    input  logic                   clk,
    input  logic                   rst,
    input  wr_req_t                wr,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [BYTE_W-1:0]      rd_data,
    output logic [LIVE*BYTE_W-1:0] flat
);
    logic [BYTE_W-1:0] mem [LIVE];

    for (genvar g = 0; g < LIVE; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= '0;
            else if (wr.en && wr.idx == IDX_W'(g))
                mem[g] <= wr.data;
        end
        assign flat[g*BYTE_W +: BYTE_W] = mem[g];
    end

    // placeholder indices fall through to zero
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < LIVE; i++) begin
            if (rd_idx == IDX_W'(i))
                rd_data = mem[i];
        end
    end

    // R8
    live_only_chk: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> (int'(wr.idx) < LIVE))
        else $error("store written outside the live range");

endmodule

// File: rtl/cfgi2c_proto.sv
module cfgi2c_proto
    import cfgi2c_pkg::*;
#(
    parameter int REGS = REG_COUNT,
    parameter int LIVE = LIVE_COUNT
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              strap,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              sda_low,
    output wr_req_t           wr
);
    phase_e               phase;
    rxkind_e              kind;
    logic [BIT_CNT_W-1:0] cnt;
    logic [BYTE_W-1:0]    sh;
    logic                 got;
    logic                 go_tx;
    logic                 ctl_ack;
    logic [IDX_W-1:0]     ptr;

    function automatic logic [IDX_W-1:0] ptr_next(input logic [IDX_W-1:0] p);
        return (int'(p) == REGS - 1) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [IDX_W-1:0] ptr_load(input logic [BYTE_W-1:0] b);
        return (int'(b) < REGS) ? b[IDX_W-1:0] : '0;
    endfunction

    assign rd_idx = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            kind    <= RK_DEV;
            cnt     <= '0;
            sh      <= '0;
            got     <= 1'b0;
            go_tx   <= 1'b0;
            ctl_ack <= 1'b0;
            ptr     <= '0;
            sda_low <= 1'b0;
            wr      <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.stop) begin
                phase   <= PH_IDLE;
                sda_low <= 1'b0;
            end else if (ev.start) begin
                phase   <= PH_RX;
                kind    <= RK_DEV;
                cnt     <= '0;
                got     <= 1'b0;
                sda_low <= 1'b0;
            end else begin
                unique case (phase)
                    PH_RX: begin
                        if (ev.rise) begin
                            sh  <= {sh[BYTE_W-2:0], ev.sda};
                            cnt <= cnt + 1'b1;
                            if (cnt == BIT_CNT_W'(BYTE_W - 1))
                                got <= 1'b1;
                        end else if (ev.fall && got) begin
                            got <= 1'b0;
                            unique case (kind)
                                RK_DEV: begin
                                    if (sh[BYTE_W-1:1] == {DEV_ADDR_HI, strap}) begin
                                        sda_low <= 1'b1;
                                        phase   <= PH_RX_ACK;
                                        go_tx   <= sh[0];
                                        kind    <= RK_PTR;
                                    end else begin
                                        phase <= PH_IDLE;
                                    end
                                end
                                RK_PTR: begin
                                    ptr     <= ptr_load(sh);
                                    sda_low <= 1'b1;
                                    phase   <= PH_RX_ACK;
                                    go_tx   <= 1'b0;
                                    kind    <= RK_DATA;
                                end
                                default: begin
                                    if (int'(ptr) < LIVE) begin
                                        wr.en   <= 1'b1;
                                        wr.idx  <= ptr;
                                        wr.data <= sh;
                                    end
                                    ptr     <= ptr_next(ptr);
                                    sda_low <= 1'b1;
                                    phase   <= PH_RX_ACK;
                                    go_tx   <= 1'b0;
                                end
                            endcase
                        end
                    end
                    PH_RX_ACK: begin
                        if (ev.fall) begin
                            cnt <= '0;
                            if (go_tx) begin
                                sh      <= rd_data;
                                ptr     <= ptr_next(ptr);
                                sda_low <= ~rd_data[BYTE_W-1];
                                phase   <= PH_TX;
                            end else begin
                                sda_low <= 1'b0;
                                phase   <= PH_RX;
                            end
                        end
                    end
                    PH_TX: begin
                        if (ev.fall) begin
                            if (cnt == BIT_CNT_W'(BYTE_W - 1)) begin
                                sda_low <= 1'b0;
                                phase   <= PH_TX_ACK;
                            end else begin
                                cnt     <= cnt + 1'b1;
                                sh      <= {sh[BYTE_W-2:0], 1'b0};
                                sda_low <= ~sh[BYTE_W-2];
                            end
                        end
                    end
                    PH_TX_ACK: begin
                        if (ev.rise) begin
                            ctl_ack <= ~ev.sda;
                        end else if (ev.fall) begin
                            cnt <= '0;
                            if (ctl_ack) begin
                                sh      <= rd_data;
                                ptr     <= ptr_next(ptr);
                                sda_low <= ~rd_data[BYTE_W-1];
                                phase   <= PH_TX;
                            end else begin
                                sda_low <= 1'b0;
                                phase   <= PH_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_low <= 1'b0;
                    end
                endcase
            end
        end
    end

    // R6
    ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(ptr) < REGS)
        else $error("pointer left the register space");

    // R9
    wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr.en |=> !wr.en)
        else $error("write strobe longer than one cycle");

    // R7
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && $past(phase) == PH_IDLE) |-> !sda_low)
        else $error("data line pulled while idle");

endmodule

// File: rtl/cfgi2c_target.sv
module cfgi2c_target
    import cfgi2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         addr_strap,
    input  logic                         scl_i,
    input  logic                         sda_i,
    output logic                         sda_pull_low,
    output logic [LIVE_COUNT*BYTE_W-1:0] cfg_flat,
    output logic                         rf_wr_en,
    output logic [IDX_W-1:0]             rf_wr_addr,
    output logic [BYTE_W-1:0]            rf_wr_data
);
    localparam int LINES = 2;  // 0: clock line, 1: data line

    logic [LINES-1:0] raw;
    logic [LINES-1:0] line_s;
    logic [LINES-1:0] line_p;

    assign raw = {sda_i, scl_i};

    for (genvar l = 0; l < LINES; l++) begin : g_sync
        cfgi2c_linesync #(
            .STAGES   (SYNC_STAGES),
            .RESET_VAL(1'b1)
        ) u_sync (
            .clk   (clk),
            .rst   (rst),
            .d     (raw[l]),
            .q     (line_s[l]),
            .q_prev(line_p[l])
        );
    end

    bus_ev_t ev;
    always_comb begin
        ev.rise  = line_s[0] & ~line_p[0];
        ev.fall  = ~line_s[0] & line_p[0];
        ev.start = line_s[0] & line_p[0] & line_p[1] & ~line_s[1];
        ev.stop  = line_s[0] & line_p[0] & ~line_p[1] & line_s[1];
        ev.sda   = line_s[1];
    end

    wr_req_t             wr;
    logic [IDX_W-1:0]    rd_idx;
    logic [BYTE_W-1:0]   rd_data;

    cfgi2c_proto #(
        .REGS(REG_COUNT),
        .LIVE(LIVE_COUNT)
    ) u_proto (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .strap  (addr_strap),
        .rd_data(rd_data),
        .rd_idx (rd_idx),
        .sda_low(sda_pull_low),
        .wr     (wr)
    );

    cfgi2c_regfile #(
        .LIVE(LIVE_COUNT)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .rd_idx (rd_idx),
        .rd_data(rd_data),
        .flat   (cfg_flat)
    );

    assign rf_wr_en   = wr.en;
    assign rf_wr_addr = wr.idx;
    assign rf_wr_data = wr.data;

    // R4
    sda_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (line_s[0] && line_p[0]) |-> $stable(sda_pull_low))
        else $error("data drive changed while clock line high");

endmodule

// File: tb/cfgi2c_target_test.sv
`timescale 1ns/1ps
module cfgi2c_target_test;
    localparam int Q      = 10;
    localparam int NREG   = 24;
    localparam int NLIVE  = 20;
    localparam int LIMIT  = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         strap = 1'b0;
    logic         scl_m = 1'b1;
    logic         sda_m = 1'b1;
    logic         sda_pull_low;
    logic [159:0] cfg_flat;
    logic         rf_wr_en;
    logic [4:0]   rf_wr_addr;
    logic [7:0]   rf_wr_data;
    wire          sda_bus = sda_m & ~sda_pull_low;

    int total = 0;
    int bad   = 0;
    bit settled = 1'b0;
    int model [NREG];
    int strobes [$];

    always #2 clk = ~clk;

    cfgi2c_target uut (
        .clk         (clk),
        .rst         (rst),
        .addr_strap  (strap),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .sda_pull_low(sda_pull_low),
        .cfg_flat    (cfg_flat),
        .rf_wr_en    (rf_wr_en),
        .rf_wr_addr  (rf_wr_addr),
        .rf_wr_data  (rf_wr_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [159:0] model_flat();
        logic [159:0] f = '0;
        for (int i = 0; i < NLIVE; i++) f[i*8 +: 8] = model[i][7:0];
        return f;
    endfunction

    function automatic int nxt(input int p);
        return (p == NREG - 1) ? 0 : p + 1;
    endfunction

    function automatic int rd_model(input int p);
        return (p < NLIVE) ? model[p] : 0;
    endfunction

    // strobe capture and per-clock store comparison (R9)
    always @(negedge clk) begin
        if (!rst && rf_wr_en) strobes.push_back(int'(rf_wr_addr) * 256 + int'(rf_wr_data));
        if (settled) begin
            total++;
            if (cfg_flat !== model_flat()) begin
                bad++;
                $display("FAIL R9 store actual=%0h expected=%0h", cfg_flat, model_flat());
            end
        end
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", LIMIT, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl_m = 1'b1; wq(2*Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        acked = !sda_bus;
        wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            wq(Q);
            scl_m = 1'b1; wq(Q);
            b = {b[6:0], sda_bus};
            wq(Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = ack ? 1'b0 : 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        if (!ack) chk(sda_bus === 1'b1, "R4 controller ack slot left free", int'(sda_bus), 1);
        wq(Q);
        scl_m = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    // write transfer: address, pointer, then data bytes
    task automatic wr_seq(input logic [6:0] dev, input int p_in, input int data [$]);
        bit a;
        int p;
        settled = 1'b0;
        bus_start();
        send_byte({dev, 1'b0}, a);
        chk(a, "R1 address ack", int'(a), 1);
        send_byte(8'(p_in), a);
        chk(a, "R2 pointer ack", int'(a), 1);
        p = (p_in < NREG) ? p_in : 0;
        foreach (data[k]) begin
            send_byte(8'(data[k]), a);
            chk(a, "R2 data ack", int'(a), 1);
            if (p < NLIVE) begin
                chk(strobes.size() == 1, "R9 strobe count", strobes.size(), 1);
                if (strobes.size() > 0) begin
                    int s = strobes.pop_front();
                    chk(s == p * 256 + data[k], "R2 strobe index and value", s, p * 256 + data[k]);
                end
                model[p] = data[k];
            end else begin
                chk(strobes.size() == 0, "R8 no strobe for placeholder", strobes.size(), 0);
                strobes.delete();
            end
            p = nxt(p);
        end
        bus_stop();
        settled = 1'b1;
    endtask

    // read transfer: write phase with pointer, repeated START, read phase
    task automatic rd_seq(input logic [6:0] dev, input int p_in, input int n, input string req);
        bit a;
        int p;
        logic [7:0] b;
        bus_start();
        send_byte({dev, 1'b0}, a);
        chk(a, "R1 address ack", int'(a), 1);
        send_byte(8'(p_in), a);
        chk(a, "R3 pointer ack", int'(a), 1);
        bus_start();
        send_byte({dev, 1'b1}, a);
        chk(a, "R3 read address ack", int'(a), 1);
        p = (p_in < NREG) ? p_in : 0;
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            chk(int'(b) == rd_model(p), req, int'(b), rd_model(p));
            p = nxt(p);
        end
    endtask

    initial begin
        bit a;
        logic [7:0] b;
        foreach (model[i]) model[i] = 0;
        wq(5);
        rst = 1'b0;
        wq(3);
        // R10
        chk(sda_pull_low === 1'b0, "R10 data line released", int'(sda_pull_low), 0);
        chk(cfg_flat === '0, "R10 store cleared", int'(cfg_flat[31:0]), 0);
        chk(rf_wr_en === 1'b0, "R10 strobe low", int'(rf_wr_en), 0);
        settled = 1'b1;

        // R2 block write, R3 read back with repeated START, R4 MSB first
        wr_seq(7'b1101110, 3, '{8'hA1, 8'hB2, 8'hC3});
        rd_seq(7'b1101110, 3, 3, "R3 read data");
        // R7 after a NACK further clocks read back released line
        recv_byte(1'b0, b);
        chk(b == 8'hFF, "R7 released after NACK", int'(b), 8'hFF);
        bus_stop();
        rd_seq(7'b1101110, 0, 1, "R10 reset value read");
        bus_stop();

        // R1 wrong address with strap 0
        bus_start();
        send_byte({7'b1101111, 1'b0}, a);
        chk(!a, "R1 foreign address not acked", int'(a), 0);
        send_byte(8'h05, a);
        chk(!a, "R1 idle until START", int'(a), 0);
        send_byte(8'h5A, a);
        chk(!a, "R1 no store after mismatch", int'(a), 0);
        bus_stop();
        chk(strobes.size() == 0, "R1 no strobe after mismatch", strobes.size(), 0);

        // R1 strap moves the address
        strap = 1'b1;
        wq(4);
        bus_start();
        send_byte({7'b1101110, 1'b0}, a);
        chk(!a, "R1 strap 1 rejects 1101110", int'(a), 0);
        bus_stop();

        // R8 placeholders, R6 wrap
        wr_seq(7'b1101111, 18, '{8'h5C, 8'h3D, 8'h11, 8'h22, 8'h33, 8'h44, 8'h6E, 8'h7F});
        rd_seq(7'b1101111, 18, 9, "R8 R6 read across placeholders and wrap");
        bus_stop();

        // R6 out-of-range pointer loads zero
        wr_seq(7'b1101111, 30, '{8'h96});
        rd_seq(7'b1101111, 0, 1, "R6 pointer byte above range");
        bus_stop();

        // R5 STOP ends the transfer
        wr_seq(7'b1101111, 10, '{8'h77});
        send_byte(8'h99, a);
        chk(!a, "R5 byte after STOP not acked", int'(a), 0);
        wq(4);
        chk(strobes.size() == 0, "R5 no store after STOP", strobes.size(), 0);
        rd_seq(7'b1101111, 10, 2, "R5 store unchanged after STOP");
        bus_stop();

        // R3 long read with wrap from 23
        rd_seq(7'b1101111, 21, 5, "R3 R6 read wrap");
        bus_stop();
        wq(20);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule